// File: doc/BRIEF.md
# Precision-Time Event Capture Slot

This block holds a single captured record for a precision-time protocol event: the 16-bit sequence identifier of the packet and a 64-bit sample of a free-running time counter. An upstream packet detector pulses a detect strobe together with the sequence identifier. The block latches the record into its one slot. A host then reads the record through three 32-bit read words and frees the slot by writing a 1 to the valid position of the status word. The slot is never overwritten: any event that arrives while the slot is occupied is discarded.

A parameter selects one of two variants. The receive variant latches the sequence identifier and the timestamp in the same cycle. The transmit variant works in two steps. The detect strobe latches the sequence identifier and whether software or hardware asked for the stamp, and marks the slot as pending. A later departure strobe latches the time, ends the pending state and sets the valid flag.

Read word layout: at address 0 the status word has bits [15:0] = sequence ID, bit 16 = valid, bit 17 = pending (transmit variant only), bit 18 = request source (1 = software, 0 = hardware; transmit variant only), and all other bits zero. Address 1 holds timestamp bits [31:0]. Address 2 holds timestamp bits [63:32]. Address 3 reads as zero.

Top module: `ptp_ts_capture`

## Requirements
- R1: After reset, all three read words are zero.
- R2: In the receive variant, a detect strobe while the slot is empty makes the status word read valid=1 with the strobed sequence ID from the next cycle, and the timestamp words then hold the time counter value present at the strobe edge.
- R3: While the valid flag is set, detect strobes (and departure strobes) leave all three read words unchanged.
- R4: A write to address 0 with bit 16 set clears every field of the slot to zero on the next cycle. A write to address 0 with bit 16 clear, or a write to any other address, changes nothing.
- R5: When a clearing write and a detect or departure strobe occur in the same cycle, the clear wins and the slot is empty afterwards.
- R6: The low and high timestamp words always come from one single 64-bit sample of the time counter.
- R7: In the transmit variant, a detect strobe while the slot is empty and not pending sets bit 17, records the sequence ID and the request source in bit 18, and leaves bit 16 and the timestamp at zero.
- R8: In the transmit variant, a departure strobe while pending latches the time counter, and in that same update clears bit 17 and sets bit 16.
- R9: In the transmit variant, a departure strobe while not pending is ignored, and a detect strobe while pending is ignored.
- R10: In the receive variant, bits 17 and 18 always read zero and the departure strobe has no effect.
- R11: Reads of address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_valid | input | 1 | Event detect strobe |
| det_seq | input | SEQ_W (16) | Sequence ID of the detected packet |
| det_sw | input | 1 | Request source for the event, 1 = software (transmit variant) |
| ts_evt | input | 1 | Departure strobe that latches the time (transmit variant) |
| time_now | input | 2*WORD_W (64) | Free-running time counter |
| wr_en | input | 1 | Host register write enable |
| wr_addr | input | ADDR_W (2) | Host write word address |
| wr_data | input | WORD_W (32) | Host write data |
| rd_addr | input | ADDR_W (2) | Host read word address |
| rd_data | output | WORD_W (32) | Read word selected by rd_addr |

## Verification
The bench builds two copies with default widths: one with TX_MODE=0 and one with TX_MODE=1. Both are driven by the same strobes, so a departure strobe the receive copy must ignore is also a live input to the transmit copy. The time counter starts near the 32-bit boundary, which lets a carry into the high word appear between captures and exposes a mix of low and high words from different samples. Clear-versus-capture collisions and drops while occupied or pending are driven both as directed cases and in the random mix.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;

    localparam int ADDR_STAT = 0;
    localparam int ADDR_TSLO = 1;
    localparam int ADDR_TSHI = 2;

    typedef struct packed {
        logic valid;
        logic pending;
        logic src;
    } slot_state_t;

    typedef struct packed {
        logic load_seq;
        logic load_ts;
    } slot_load_t;

endpackage

// File: rtl/ptp_ts_ctrl.sv
module ptp_ts_ctrl
    import ptp_ts_pkg::*;
#(
    parameter bit TX_MODE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        det_valid,
    input  logic        det_sw,
    input  logic        ts_evt,
    input  logic        clear,
    output slot_state_t state,
    output slot_load_t  load
);

    slot_state_t st_d, st_q;
    slot_load_t  ld;

    always_comb begin
        st_d = st_q;
        ld   = '0;
        if (clear) begin
            st_d = '0;
        end else if (TX_MODE) begin
            if (!st_q.valid && !st_q.pending && det_valid) begin
                st_d.pending = 1'b1;
                st_d.src     = det_sw;
                ld.load_seq  = 1'b1;
            end else if (st_q.pending && ts_evt) begin
                st_d.pending = 1'b0;
                st_d.valid   = 1'b1;
                ld.load_ts   = 1'b1;
            end
        end else begin
            if (!st_q.valid && det_valid) begin
                st_d.valid  = 1'b1;
                ld.load_seq = 1'b1;
                ld.load_ts  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state = st_q;
    assign load  = ld;

    p_excl_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.valid && st_q.pending));

    p_ts_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pending && ts_evt && !clear) |=> (st_q.valid && !st_q.pending));

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!st_q.valid && !st_q.pending && !st_q.src));

    p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pending && !ts_evt && !clear) |=> (st_q.pending && $stable(st_q.src)));

endmodule

// File: rtl/ptp_ts_store.sv
module ptp_ts_store
    import ptp_ts_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int TS_W  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  slot_load_t       load,
    input  logic [SEQ_W-1:0] det_seq,
    input  logic [TS_W-1:0]  time_now,
    output logic [SEQ_W-1:0] seq,
    output logic [TS_W-1:0]  ts
);

    typedef struct packed {
        logic [SEQ_W-1:0] seq;
        logic [TS_W-1:0]  ts;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (clear) begin
            rec_d = '0;
        end else begin
            if (load.load_seq) rec_d.seq = det_seq;
            if (load.load_ts)  rec_d.ts  = time_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign seq = rec_q.seq;
    assign ts  = rec_q.ts;

    p_ts_one_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load.load_ts && !clear) |=> (ts == $past(time_now)));

endmodule

// File: rtl/ptp_ts_regif.sv
module ptp_ts_regif
    import ptp_ts_pkg::*;
#(
    parameter int SEQ_W  = 16,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  slot_state_t       state,
    input  logic [SEQ_W-1:0]  seq,
    input  logic [2*WORD_W-1:0] ts,
    output logic              clear,
    output logic [WORD_W-1:0] rd_data
);

    localparam int VLD_BIT  = SEQ_W;
    localparam int PEND_BIT = SEQ_W + 1;
    localparam int SRC_BIT  = SEQ_W + 2;

    logic [WORD_W-1:0] stat_word;
    logic              unused_wr;

    assign clear = wr_en && (wr_addr == ADDR_W'(ADDR_STAT)) && wr_data[VLD_BIT];
    assign unused_wr = ^{wr_data[WORD_W-1:VLD_BIT+1], wr_data[VLD_BIT-1:0]};

    always_comb begin
        stat_word                = '0;
        stat_word[SEQ_W-1:0]     = seq;
        stat_word[VLD_BIT]       = state.valid;
        stat_word[PEND_BIT]      = state.pending;
        stat_word[SRC_BIT]       = state.src;
    end

    always_comb begin
        case (rd_addr)
            ADDR_W'(ADDR_STAT): rd_data = stat_word;
            ADDR_W'(ADDR_TSLO): rd_data = ts[WORD_W-1:0];
            ADDR_W'(ADDR_TSHI): rd_data = ts[2*WORD_W-1:WORD_W];
            default:            rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ptp_ts_capture.sv
module ptp_ts_capture
    import ptp_ts_pkg::*;
#(
    parameter int SEQ_W   = 16,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 2,
    parameter bit TX_MODE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                det_valid,
    input  logic [SEQ_W-1:0]    det_seq,
    input  logic                det_sw,
    input  logic                ts_evt,
    input  logic [2*WORD_W-1:0] time_now,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data
);

    localparam int TS_W = 2 * WORD_W;

    slot_state_t      state;
    slot_load_t       load;
    logic             clear;
    logic [SEQ_W-1:0] seq;
    logic [TS_W-1:0]  ts;

    ptp_ts_ctrl #(.TX_MODE(TX_MODE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .det_valid (det_valid),
        .det_sw    (det_sw),
        .ts_evt    (ts_evt),
        .clear     (clear),
        .state     (state),
        .load      (load)
    );

    ptp_ts_store #(.SEQ_W(SEQ_W), .TS_W(TS_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .load     (load),
        .det_seq  (det_seq),
        .time_now (time_now),
        .seq      (seq),
        .ts       (ts)
    );

    ptp_ts_regif #(.SEQ_W(SEQ_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regif (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .state     (state),
        .seq       (seq),
        .ts        (ts),
        .clear     (clear),
        .rd_data   (rd_data)
    );

    p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state.valid && !clear) |=> ($stable(seq) && $stable(ts) && state.valid));

    p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (seq == '0 && ts == '0));

    p_pending_no_ts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!state.valid && !state.pending && !clear) |=> (state.valid || ts == '0));

    generate
        if (!TX_MODE) begin : g_rx_chk
            p_rx_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (!state.valid && det_valid && !clear) |=>
                    (state.valid && seq == $past(det_seq) && ts == $past(time_now)));
        end
    endgenerate

endmodule

// File: tb/ptp_ts_capture_tb.sv
module ptp_ts_capture_tb;

    localparam int SEQ_W  = 16;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                det_valid = 1'b0;
    logic [SEQ_W-1:0]    det_seq = '0;
    logic                det_sw = 1'b0;
    logic                ts_evt = 1'b0;
    logic [2*WORD_W-1:0] time_now = 64'h0000_0000_FFFF_FF00;
    logic                wr_en = 1'b0;
    logic [ADDR_W-1:0]   wr_addr = '0;
    logic [WORD_W-1:0]   wr_data = '0;
    logic [ADDR_W-1:0]   rd_addr = '0;
    logic [WORD_W-1:0]   rd_rx, rd_tx;

    int checks = 0;
    int errors = 0;

    // bench model, index 0 = receive copy, 1 = transmit copy
    logic        m_v [2];
    logic        m_p [2];
    logic        m_s [2];
    logic [15:0] m_seq [2];
    logic [63:0] m_ts [2];

    always #10 clk = ~clk;

    ptp_ts_capture #(.SEQ_W(SEQ_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .TX_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .det_valid(det_valid), .det_seq(det_seq), .det_sw(det_sw),
        .ts_evt(ts_evt), .time_now(time_now), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_rx));

    ptp_ts_capture #(.SEQ_W(SEQ_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .TX_MODE(1'b1)) u_dut_tx (
        .clk(clk), .rst_n(rst_n), .det_valid(det_valid), .det_seq(det_seq), .det_sw(det_sw),
        .ts_evt(ts_evt), .time_now(time_now), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_tx));

    function automatic logic [31:0] exp_word(int idx, int addr);
        case (addr)
            0: return {13'd0, m_s[idx], m_p[idx], m_v[idx], m_seq[idx]};
            1: return m_ts[idx][31:0];
            2: return m_ts[idx][63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_v[i] = 0; m_p[i] = 0; m_s[i] = 0; m_seq[i] = '0; m_ts[i] = '0;
        end
    endtask

    // next-state of the model from the inputs present before the edge
    task automatic model_step();
        logic clr;
        clr = wr_en && (wr_addr == 2'd0) && wr_data[16];
        if (clr) begin
            model_reset();
        end else begin
            if (!m_v[0] && det_valid) begin
                m_v[0] = 1; m_seq[0] = det_seq; m_ts[0] = time_now;
            end
            if (!m_v[1] && !m_p[1] && det_valid) begin
                m_p[1] = 1; m_s[1] = det_sw; m_seq[1] = det_seq;
            end else if (m_p[1] && ts_evt) begin
                m_p[1] = 0; m_v[1] = 1; m_ts[1] = time_now;
            end
        end
    endtask

    task automatic check_all(string tag);
        for (int a = 0; a < 4; a++) begin
            rd_addr = ADDR_W'(a);
            #1;
            checks++;
            if (rd_rx !== exp_word(0, a)) begin
                errors++;
                $display("FAIL %s rx addr %0d actual %h expected %h", tag, a, rd_rx, exp_word(0, a));
            end
            checks++;
            if (rd_tx !== exp_word(1, a)) begin
                errors++;
                $display("FAIL %s tx addr %0d actual %h expected %h", tag, a, rd_tx, exp_word(1, a));
            end
        end
    endtask

    // inputs are set at a negedge; apply one edge and check at the next negedge
    task automatic cycle(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        det_valid = 0; ts_evt = 0; wr_en = 0; wr_data = '0; wr_addr = '0;
        time_now = time_now + 64'd37;
        check_all(tag);
    endtask

    task automatic do_clear();
        wr_en = 1; wr_addr = 2'd0; wr_data = 32'h0001_0000;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1;
        @(negedge clk);
        check_all("R1 after reset");

        // R10 / R9: departure strobe with nothing pending
        ts_evt = 1; cycle("R9 R10 stray departure");

        // R2 / R7: detect into empty slot
        det_valid = 1; det_seq = 16'hA5C3; det_sw = 1; cycle("R2 R7 first detect");
        // R3 / R9: second detect is dropped by both
        det_valid = 1; det_seq = 16'h1111; det_sw = 0; cycle("R3 R9 detect while held");
        // R8: departure latches time on tx copy; R3/R10: rx copy unchanged
        ts_evt = 1; cycle("R8 R10 departure");
        ts_evt = 1; det_valid = 1; det_seq = 16'h2222; cycle("R3 held after valid");
        // R4: writes that must not clear
        wr_en = 1; wr_addr = 2'd0; wr_data = 32'hFFFE_FFFF; cycle("R4 write without bit16");
        wr_en = 1; wr_addr = 2'd1; wr_data = 32'hFFFF_FFFF; cycle("R4 write other addr");
        wr_en = 1; wr_addr = 2'd2; wr_data = 32'h0001_0000; cycle("R4 bit16 other addr");
        do_clear(); cycle("R4 clear");
        // R5: clear in the same cycle as detect
        do_clear(); det_valid = 1; det_seq = 16'h3333; cycle("R5 clear vs detect");
        // R5: clear in the same cycle as departure
        det_valid = 1; det_seq = 16'h4444; det_sw = 0; cycle("R7 hw request");
        do_clear(); ts_evt = 1; cycle("R5 clear vs departure");
        // R6: capture across a carry into the high word
        time_now = 64'h0000_0001_FFFF_FFFF;
        det_valid = 1; det_seq = 16'hBEEF; cycle("R6 carry capture");
        time_now = 64'h0000_0002_0000_0000;
        ts_evt = 1; cycle("R6 R8 carry departure");
        check_all("R11 addr3 zero");
        do_clear(); cycle("R4 clear again");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            det_valid = ($urandom % 3) == 0;
            det_seq   = 16'($urandom);
            det_sw    = 1'($urandom);
            ts_evt    = ($urandom % 3) == 0;
            if (($urandom % 6) == 0) begin
                wr_en   = 1;
                wr_addr = 2'($urandom);
                wr_data = $urandom;
            end
            if (($urandom % 50) == 0) time_now = {$urandom, $urandom};
            cycle("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule